// File: doc/BRIEF.md
# Hart Interrupt Pending Aggregator

This block gathers the level-sensitive interrupt request lines of one hart that runs with the hypervisor extension. It registers them into a machine-level pending vector. Twelve local lines feed the software, timer and external pending bits of the user, supervisor, virtual-supervisor and machine levels. A separate bank of guest external lines feeds a guest pending vector. An enable mask gates that guest vector, and its reduction produces the supervisor guest-external summary bit at index 12 of the main vector.

The supervisor external pending bit at index 9 has two sources. One is the hardware line and the other is a software-held bit, so releasing one source never hides the other. The wake output is asserted when any pending bit meets its enable. Privilege level and delegation play no part in it, so an idle hart can use this output directly to resume. Software reaches the held bit, the enable vector, the guest enable mask and the claim mask through a strobed synchronous write port. All of these registers can be read back on output ports.

Top module: `hart_irq_pending_agg`

## Requirements
- R1: Each local line i in 0..11 other than 9 appears on pending bit i one clock edge after it is sampled.
- R2: Pending bit 9 is high exactly when the registered local line 9 or the software-held external bit is high. Dropping either source leaves the bit high while the other source remains high.
- R3: Guest line k drives guest pending bit k+1 one edge later when k+1 does not exceed GuestCount. Guest pending bit 0 is always 0.
- R4: A guest line with k+1 greater than GuestCount sets errFlag one edge later and changes no guest pending bit.
- R5: Pending bit 12 is 1 exactly when the registered guest pending vector ANDed with the guest enable mask is nonzero.
- R6: wake equals the OR-reduction of pendVec AND ieVec. No other input affects it.
- R7: After reset, claimMask holds only bit 12. The pending, enable, guest and software-held state and errFlag are all 0.
- R8: The wrSwSeip strobe loads wrData[0] into the software-held bit. The wrIe strobe loads wrData bits 0..12 into ieVec, and bits 13..15 stay 0. The wrGeie strobe loads wrData into geieVec, except that bit 0 ignores the write and stays 0. The wrClaim strobe loads wrData[15:0] into claimMask. Each write takes effect on the next edge, and a register whose strobe is low keeps its value.
- R9: pendVec bits 13..15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localReq | input | 12 | Local interrupt request levels |
| guestReq | input | GuestLines | Guest external request levels, line k maps to bit k+1 |
| wrSwSeip | input | 1 | Write strobe for the software external pending bit |
| wrIe | input | 1 | Write strobe for the enable vector |
| wrGeie | input | 1 | Write strobe for the guest enable mask |
| wrClaim | input | 1 | Write strobe for the claim mask |
| wrData | input | DataW | Write data shared by all strobes |
| pendVec | output | 16 | Machine interrupt pending vector |
| guestPend | output | GuestCount+1 | Guest external pending vector |
| ieVec | output | 16 | Interrupt enable vector |
| geieVec | output | GuestCount+1 | Guest enable mask |
| claimMask | output | 16 | Interrupt claim mask |
| swSeip | output | 1 | Software-held supervisor external pending bit |
| wake | output | 1 | Any enabled interrupt pending |
| errFlag | output | 1 | An out-of-range guest line was high in the previous cycle |

## Verification
A stale or corrupted line register shows up on pendVec one cycle after the stimulus, and it reaches wake in the same cycle whenever the enable for that bit is set. A wrong software-held bit or guest enable mask is hidden until it is combined with the other source. The bench therefore releases the hardware external line while the software bit is still set, and it changes the guest enables while guest lines are both high and low. Any wrong value then reaches bit 9 or bit 12 within one edge. A lost drop of an illegal line, or a wrongly mapped guest line, shows at once on guestPend or errFlag.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int LocalLines = 12;
  localparam int PendW      = 16;
  localparam int SeiIdx     = 9;
  localparam int SgeiIdx    = 12;
  localparam int ImplBits   = SgeiIdx + 1;

  typedef struct packed {
    logic wrSw;
    logic wrIe;
    logic wrGeie;
    logic wrClaim;
  } wrStrobes_t;
endpackage

// File: rtl/hip_ctrl.sv
module hip_ctrl #(
  parameter int GuestLines = 8,
  parameter int GuestCount = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [GuestLines-1:0]    guestReq,
  input  logic                     wrSwSeip,
  input  logic                     wrIe,
  input  logic                     wrGeie,
  input  logic                     wrClaim,
  output hip_pkg::wrStrobes_t      strb,
  output logic                     errFlag
);
  logic [GuestLines-1:0] illegalMask;
  logic                  illegalAny;
  logic                  errQ;

  for (genvar k = 0; k < GuestLines; k++) begin : gIllegal
    if (k + 1 > GuestCount) begin : gOut
      assign illegalMask[k] = 1'b1;
    end else begin : gIn
      assign illegalMask[k] = 1'b0;
    end
  end

  assign illegalAny = |(guestReq & illegalMask);

  always_comb begin
    strb.wrSw    = wrSwSeip;
    strb.wrIe    = wrIe;
    strb.wrGeie  = wrGeie;
    strb.wrClaim = wrClaim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= illegalAny;
  end

  assign errFlag = errQ;

  // R4: an out-of-range guest line raises the flag on the next edge
  p_illegal_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    illegalAny |=> errFlag);
  // R4: with every guest line quiet the flag drops on the next edge
  p_quiet_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (guestReq == '0) |=> !errFlag);
endmodule

// File: rtl/hip_dp.sv
module hip_dp #(
  parameter int GuestLines = 8,
  parameter int GuestW     = 6,
  parameter int DataW      = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [hip_pkg::LocalLines-1:0]    localReq,
  input  logic [GuestLines-1:0]             guestReq,
  input  hip_pkg::wrStrobes_t               strb,
  input  logic [DataW-1:0]                  wrData,
  output logic [hip_pkg::PendW-1:0]         pendVec,
  output logic [GuestW-1:0]                 guestPend,
  output logic [hip_pkg::PendW-1:0]         ieVec,
  output logic [GuestW-1:0]                 geieVec,
  output logic [hip_pkg::PendW-1:0]         claimMask,
  output logic                              swSeip,
  output logic                              wake
);
  import hip_pkg::*;

  localparam logic [PendW-1:0] ImplMask  = PendW'((1 << ImplBits) - 1);
  localparam logic [PendW-1:0] ClaimInit = PendW'(1) << SgeiIdx;

  logic [LocalLines-1:0] lineQ;
  logic                  swQ;
  logic [PendW-1:0]      ieQ;
  logic [GuestW-1:0]     geieQ;
  logic [GuestW-1:0]     guestQ;
  logic [GuestW-1:0]     guestNext;
  logic [PendW-1:0]      claimQ;
  logic [PendW-1:0]      pendComb;
  logic                  sgeiSum;

  assign guestNext[0] = 1'b0;
  for (genvar b = 1; b < GuestW; b++) begin : gGuest
    if (b - 1 < GuestLines) begin : gLine
      assign guestNext[b] = guestReq[b-1];
    end else begin : gNone
      assign guestNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ  <= '0;
      swQ    <= 1'b0;
      ieQ    <= '0;
      geieQ  <= '0;
      guestQ <= '0;
      claimQ <= ClaimInit;
    end else begin
      lineQ  <= localReq;
      guestQ <= guestNext;
      if (strb.wrSw)    swQ    <= wrData[0];
      if (strb.wrIe)    ieQ    <= wrData[PendW-1:0] & ImplMask;
      if (strb.wrGeie)  geieQ  <= {wrData[GuestW-1:1], 1'b0};
      if (strb.wrClaim) claimQ <= wrData[PendW-1:0];
    end
  end

  assign sgeiSum = |(guestQ & geieQ);

  for (genvar i = 0; i < PendW; i++) begin : gPend
    if (i == SeiIdx) begin : gSei
      assign pendComb[i] = lineQ[i] | swQ;
    end else if (i < LocalLines) begin : gLocal
      assign pendComb[i] = lineQ[i];
    end else if (i == SgeiIdx) begin : gSgei
      assign pendComb[i] = sgeiSum;
    end else begin : gZero
      assign pendComb[i] = 1'b0;
    end
  end

  assign pendVec   = pendComb;
  assign guestPend = guestQ;
  assign ieVec     = ieQ;
  assign geieVec   = geieQ;
  assign claimMask = claimQ;
  assign swSeip    = swQ;
  assign wake      = |(pendComb & ieQ);

  // R1: local lines other than 9 reach their pending bit one edge later
  p_local_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((pendVec[LocalLines-1:0] ^ $past(localReq)) & ~(LocalLines'(1) << SeiIdx)) == '0);
  // R2: either source of the external bit keeps pending bit 9 high
  p_sei_hw_r2: assert property (@(posedge clk) disable iff (!rstN)
    localReq[SeiIdx] |=> pendVec[SeiIdx]);
  p_sei_sw_r2: assert property (@(posedge clk) disable iff (!rstN)
    swSeip |-> pendVec[SeiIdx]);
  // R3: guest bit 0 is never set
  p_guest_bit0_r3: assert property (@(posedge clk) disable iff (!rstN)
    guestPend[0] == 1'b0);
  // R5: the summary bit tracks enabled guest pending bits
  p_sgei_sum_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((guestPend & geieVec) == '0) |-> !pendVec[SgeiIdx]);
  // R6: wake follows the enabled pending bits
  p_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ieVec) != '0) |-> wake);
  // R8: enable writes land on the next edge
  p_ie_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIe |=> ieVec == ($past(wrData[PendW-1:0]) & ImplMask));
  p_ie_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrIe |=> $stable(ieVec));
  // R9: unused pending bits stay clear
  p_pend_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[PendW-1:ImplBits] == '0);
endmodule

// File: rtl/hart_irq_pending_agg.sv
module hart_irq_pending_agg #(
  parameter int GuestLines = 8,
  parameter int GuestCount = 5,
  localparam int GuestW    = GuestCount + 1,
  localparam int DataW     = (GuestW > hip_pkg::PendW) ? GuestW : hip_pkg::PendW
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [hip_pkg::LocalLines-1:0] localReq,
  input  logic [GuestLines-1:0]          guestReq,
  input  logic                           wrSwSeip,
  input  logic                           wrIe,
  input  logic                           wrGeie,
  input  logic                           wrClaim,
  input  logic [DataW-1:0]               wrData,
  output logic [hip_pkg::PendW-1:0]      pendVec,
  output logic [GuestW-1:0]              guestPend,
  output logic [hip_pkg::PendW-1:0]      ieVec,
  output logic [GuestW-1:0]              geieVec,
  output logic [hip_pkg::PendW-1:0]      claimMask,
  output logic                           swSeip,
  output logic                           wake,
  output logic                           errFlag
);
  hip_pkg::wrStrobes_t strb;

  hip_ctrl #(.GuestLines(GuestLines), .GuestCount(GuestCount)) uCtrl (
    .clk(clk), .rstN(rstN), .guestReq(guestReq),
    .wrSwSeip(wrSwSeip), .wrIe(wrIe), .wrGeie(wrGeie), .wrClaim(wrClaim),
    .strb(strb), .errFlag(errFlag)
  );

  hip_dp #(.GuestLines(GuestLines), .GuestW(GuestW), .DataW(DataW)) uDp (
    .clk(clk), .rstN(rstN), .localReq(localReq), .guestReq(guestReq),
    .strb(strb), .wrData(wrData), .pendVec(pendVec), .guestPend(guestPend),
    .ieVec(ieVec), .geieVec(geieVec), .claimMask(claimMask),
    .swSeip(swSeip), .wake(wake)
  );
endmodule

// File: tb/hart_irq_pending_agg_test.sv
module hart_irq_pending_agg_test;
  localparam int GL = 8;
  localparam int GC = 5;
  localparam int GW = GC + 1;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0]   localReq = '0;
  logic [GL-1:0] guestReq = '0;
  logic wrSwSeip = 1'b0, wrIe = 1'b0, wrGeie = 1'b0, wrClaim = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [15:0]   pendVec, ieVec, claimMask;
  logic [GW-1:0] guestPend, geieVec;
  logic swSeip, wake, errFlag;

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [11:0]   mLine;
  logic          mSw, mErr;
  logic [15:0]   mIe, mClaim;
  logic [GW-1:0] mGeie, mGuest;

  always #5 clk = ~clk;

  hart_irq_pending_agg #(.GuestLines(GL), .GuestCount(GC)) uut (
    .clk(clk), .rstN(rstN), .localReq(localReq), .guestReq(guestReq),
    .wrSwSeip(wrSwSeip), .wrIe(wrIe), .wrGeie(wrGeie), .wrClaim(wrClaim),
    .wrData(wrData), .pendVec(pendVec), .guestPend(guestPend), .ieVec(ieVec),
    .geieVec(geieVec), .claimMask(claimMask), .swSeip(swSeip), .wake(wake),
    .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      mLine = '0; mSw = 0; mIe = '0; mGeie = '0; mGuest = '0; mErr = 0;
      mClaim = 16'h1000;
    end else begin
      mLine = localReq;
      if (wrSwSeip) mSw = wrData[0];
      if (wrIe)     mIe = wrData & 16'h1FFF;
      if (wrGeie)   mGeie = wrData[GW-1:0] & ~GW'(1);
      if (wrClaim)  mClaim = wrData;
      mErr = 0;
      for (int k = 0; k < GL; k++) begin
        if (k + 1 <= GC) mGuest[k+1] = guestReq[k];
        else if (guestReq[k]) mErr = 1;
      end
    end
  endtask

  task automatic compare();
    logic [15:0] ep;
    ep = '0;
    for (int i = 0; i < 12; i++) ep[i] = mLine[i];
    ep[9]  = mLine[9] | mSw;
    ep[12] = |(mGuest & mGeie);
    vecs++;
    chk("R1 local pending", 64'(pendVec & 16'h0DFF), 64'(ep & 16'h0DFF));
    chk("R2 external bit9", 64'(pendVec[9]), 64'(ep[9]));
    chk("R3 guest pending", 64'(guestPend), 64'(mGuest));
    chk("R4 errFlag", 64'(errFlag), 64'(mErr));
    chk("R5 summary bit12", 64'(pendVec[12]), 64'(ep[12]));
    chk("R6 wake", 64'(wake), 64'(|(ep & mIe)));
    chk("R7 claimMask", 64'(claimMask), 64'(mClaim));
    chk("R8 ieVec", 64'(ieVec), 64'(mIe));
    chk("R8 geieVec", 64'(geieVec), 64'(mGeie));
    chk("R8 swSeip", 64'(swSeip), 64'(mSw));
    chk("R9 high bits", 64'(pendVec[15:13]), 64'(0));
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    #2;
    compare();
    wrSwSeip = 0; wrIe = 0; wrGeie = 0; wrClaim = 0;
  endtask

  task automatic wr(input int sel, input logic [DW-1:0] d);
    wrData = d;
    case (sel)
      0: wrSwSeip = 1;
      1: wrIe = 1;
      2: wrGeie = 1;
      default: wrClaim = 1;
    endcase
    step();
  endtask

  initial begin
    step(); step();
    // R7: reset state
    rstN = 1'b1;
    step();
    // R1: walk each local line
    for (int i = 0; i < 12; i++) begin localReq = 12'(1 << i); step(); end
    localReq = 12'hAAA; step();
    localReq = 12'h555; step();
    localReq = '0; step();
    // R6: enable all and observe wake
    wr(1, 16'hFFFF);
    localReq = 12'h080; step();
    localReq = '0; step();
    // R2: both sources of bit 9, release each in turn
    localReq = 12'h200; step();
    wr(0, 16'h0001);
    localReq = '0; step(); step();
    wr(0, 16'h0000);
    localReq = 12'h200; wr(0, 16'h0001);
    wr(0, 16'h0000);
    localReq = '0; step();
    // R3, R5: legal guest lines with enable changes
    guestReq = 8'h01; step();
    wr(2, 16'h003F);
    guestReq = 8'h10; step();
    wr(2, 16'h0004);
    guestReq = 8'h02; step();
    guestReq = '0; step();
    // R4: out-of-range lines flag and leave guest state alone
    guestReq = 8'hE0; step();
    guestReq = 8'hE8; step();
    guestReq = '0; step();
    // R8: claim and enable writes, bit0 of guest enable ignored
    wr(3, 16'h0000);
    wr(3, 16'hBEEF);
    wr(2, 16'h0001);
    wr(1, 16'h0000);
    // random mix
    for (int n = 0; n < 400; n++) begin
      localReq = 12'($urandom);
      guestReq = GL'($urandom) & (($urandom % 3 == 0) ? 8'hFF : 8'h1F);
      wrData = DW'($urandom);
      wrSwSeip = ($urandom % 5 == 0);
      wrIe     = ($urandom % 6 == 0);
      wrGeie   = ($urandom % 6 == 0);
      wrClaim  = ($urandom % 9 == 0);
      step();
    end
    // R7: reset again mid-run
    rstN = 1'b0; step();
    rstN = 1'b1; step();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule